// File: doc/BRIEF.md
# Master-Mode Line/Frame Sync and Shutter Timer

This block is the free-running timing generator of a rolling-shutter image sensor operating as sync master. A pixel-clock counter walks across each line of a programmable length, and a line counter walks down the frame up to a programmable line count. From these two counters the block drives an active-low vertical sync and an active-low horizontal sync, each with a programmable width. It also drives a one-clock frame-start strobe and a one-clock shutter-start strobe on the line chosen by the shutter setting. It reports the resulting integration length in lines.

All timing settings arrive on plain input buses. They are staged and copied into a working set only when the frame wraps. A value written at any point in a frame governs the whole of the following frame, and the current frame keeps its timing to the end. Values that would break the timing are forced into range as they are copied. Long exposures come from raising the frame length. The integration length equals the frame length minus the shutter line minus one.

Top module: `frame_sync_gen`

## Requirements
- R1: While `rst` is high, both counters sit at zero. The working settings are loaded from the input buses, so `frame_start` is 1, `vsync_n` is 0 and `exposure_lines` reflects the inputs. The first clock after release is pixel 0 of line 0.
- R2: Each line lasts the working line length in clocks. `hsync_n` is 0 for the first `hsync_width` clocks of every line and 1 for the rest. A width at or above the line length holds it low all line.
- R3: A frame is the working frame length in lines. `frame_start` is 1 for exactly one clock, at pixel 0 of line 0.
- R4: `vsync_n` is 0 during lines 0 to 2^sel−1 of each frame, where `vsync_width_sel` is 0→1, 1→2, 2→4 or 3→8 lines. It is 0 for the whole frame when that exceeds the frame length.
- R5: `shutter_start` is 1 for exactly one clock, at pixel 0 of the line equal to the working shutter line, once per frame.
- R6: A shutter line below 1 is used as 1. A shutter line above frame length − 1 is used as frame length − 1, where frame length is the one loaded with it.
- R7: A line length or frame length below 2 is used as 2.
- R8: `exposure_lines` equals working frame length − (working shutter line + 1) and stays fixed through a frame.
- R9: Inputs are sampled only on the clock edge that ends the last clock of a frame. The value present on that edge governs the whole next frame, and earlier mid-frame values are discarded, including a write landing in that very last clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_len | input | 16 | Clocks per line (staged) |
| frame_len | input | 18 | Lines per frame (staged) |
| shutter_line | input | 18 | Line on which the shutter starts (staged) |
| vsync_width_sel | input | 2 | Vertical sync width code: 1, 2, 4 or 8 lines (staged) |
| hsync_width | input | 16 | Horizontal sync width in clocks (staged) |
| vsync_n | output | 1 | Active-low vertical sync |
| hsync_n | output | 1 | Active-low horizontal sync |
| frame_start | output | 1 | One-clock strobe at pixel 0 of line 0 |
| shutter_start | output | 1 | One-clock strobe at pixel 0 of the shutter line |
| exposure_lines | output | 18 | Integration length of the running frame in lines |

## Verification
The settings reload and the frame wrap fall on the same clock edge. A bus write landing in the last clock of a frame is the critical case, because it must be taken whole into the next frame. The bench provokes this by writing one set early in a frame and overwriting it with another in that frame's final clock. It then judges every clock of the next frame against the overwriting set, including its clamped shutter line and its 8-line vertical sync. The remaining frames probe clamping at both ends of the shutter range, the frame-length limit on vertical sync, degenerate line and frame lengths, and a sync width equal to the line length.

// File: rtl/fsync_pkg.sv
package fsync_pkg;

    localparam int PIX_W  = 16;
    localparam int LINE_W = 18;
    localparam int VSEL_W = 2;

    typedef logic [PIX_W-1:0]  pix_t;
    typedef logic [LINE_W-1:0] line_t;

    localparam pix_t  PIX_MIN  = pix_t'(2);
    localparam line_t LINE_MIN = line_t'(2);

    typedef struct packed {
        pix_t               hlen;
        line_t              vlen;
        line_t              shut;
        logic [VSEL_W-1:0]  vsel;
        pix_t               hsw;
    } tcfg_t;

    // Number of lines covered by the vertical sync for a width code
    function automatic line_t vsync_lines(input logic [VSEL_W-1:0] sel);
        return line_t'(1) << sel;
    endfunction

    // Force staged settings into their legal ranges
    function automatic tcfg_t sanitize(input tcfg_t raw);
        tcfg_t c;
        c = raw;
        if (raw.hlen < PIX_MIN)  c.hlen = PIX_MIN;
        if (raw.vlen < LINE_MIN) c.vlen = LINE_MIN;
        if (raw.shut < line_t'(1))
            c.shut = line_t'(1);
        else if (raw.shut > c.vlen - line_t'(1))
            c.shut = c.vlen - line_t'(1);
        return c;
    endfunction

endpackage

// File: rtl/cfg_shadow.sv
module cfg_shadow
    import fsync_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  tcfg_t staged,
    output tcfg_t active
);

    always_ff @(posedge clk) begin
        if (rst || load)
            active <= sanitize(staged);
    end

endmodule

// File: rtl/scan_counter.sv
module scan_counter
    import fsync_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pix_t  hlen,
    input  line_t vlen,
    output pix_t  px,
    output line_t ln,
    output logic  frame_end
);

    logic line_end;

    assign line_end  = (px >= hlen - pix_t'(1));
    assign frame_end = line_end && (ln >= vlen - line_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            px <= '0;
            ln <= '0;
        end else if (line_end) begin
            px <= '0;
            ln <= frame_end ? '0 : ln + line_t'(1);
        end else begin
            px <= px + pix_t'(1);
        end
    end

endmodule

// File: rtl/pulse_gen.sv
module pulse_gen
    import fsync_pkg::*;
(
    input  tcfg_t cfg,
    input  pix_t  px,
    input  line_t ln,
    output logic  vsync_n,
    output logic  hsync_n,
    output logic  frame_start,
    output logic  shutter_start,
    output line_t exposure_lines
);

    logic line_head;

    assign line_head      = (px == '0);
    assign vsync_n        = !(ln < vsync_lines(cfg.vsel));
    assign hsync_n        = !(px < cfg.hsw);
    assign frame_start    = line_head && (ln == '0);
    assign shutter_start  = line_head && (ln == cfg.shut);
    assign exposure_lines = cfg.vlen - cfg.shut - line_t'(1);

endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen
    import fsync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PIX_W-1:0]  line_len,
    input  logic [LINE_W-1:0] frame_len,
    input  logic [LINE_W-1:0] shutter_line,
    input  logic [VSEL_W-1:0] vsync_width_sel,
    input  logic [PIX_W-1:0]  hsync_width,
    output logic              vsync_n,
    output logic              hsync_n,
    output logic              frame_start,
    output logic              shutter_start,
    output logic [LINE_W-1:0] exposure_lines
);

    tcfg_t staged;
    tcfg_t active;
    pix_t  px;
    line_t ln;
    logic  frame_end;

    assign staged = '{hlen: line_len, vlen: frame_len, shut: shutter_line,
                      vsel: vsync_width_sel, hsw: hsync_width};

    cfg_shadow u_shadow (
        .clk    (clk),
        .rst    (rst),
        .load   (frame_end),
        .staged (staged),
        .active (active)
    );

    scan_counter u_count (
        .clk       (clk),
        .rst       (rst),
        .hlen      (active.hlen),
        .vlen      (active.vlen),
        .px        (px),
        .ln        (ln),
        .frame_end (frame_end)
    );

    pulse_gen u_pulse (
        .cfg            (active),
        .px             (px),
        .ln             (ln),
        .vsync_n        (vsync_n),
        .hsync_n        (hsync_n),
        .frame_start    (frame_start),
        .shutter_start  (shutter_start),
        .exposure_lines (exposure_lines)
    );

endmodule

// File: rtl/fsync_checker.sv
module fsync_checker
    import fsync_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        vsync_n,
    input logic        frame_start,
    input logic        shutter_start,
    input logic [LINE_W-1:0] exposure_lines
);

    AST_FRAME_VSYNC_LOW: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> !vsync_n);                                   // R4

    AST_FRAME_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);                               // R3

    AST_SHUTTER_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        shutter_start |=> !shutter_start);                           // R5

    AST_SHUTTER_NOT_LINE0: assert property (@(posedge clk) disable iff (rst)
        shutter_start |-> !frame_start);                             // R6

    AST_EXPO_HELD: assert property (@(posedge clk) disable iff (rst)
        !frame_start |-> $stable(exposure_lines));                   // R8

endmodule

bind frame_sync_gen fsync_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .vsync_n        (vsync_n),
    .frame_start    (frame_start),
    .shutter_start  (shutter_start),
    .exposure_lines (exposure_lines)
);

// File: tb/frame_sync_gen_test.sv
`timescale 1ns/1ps
module frame_sync_gen_test;
    import fsync_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst;
    pix_t        line_len, hsync_width;
    line_t       frame_len, shutter_line;
    logic [1:0]  vsync_width_sel;
    logic        vsync_n, hsync_n, frame_start, shutter_start;
    line_t       exposure_lines;

    frame_sync_gen uut (
        .clk(clk), .rst(rst), .line_len(line_len), .frame_len(frame_len),
        .shutter_line(shutter_line), .vsync_width_sel(vsync_width_sel),
        .hsync_width(hsync_width), .vsync_n(vsync_n), .hsync_n(hsync_n),
        .frame_start(frame_start), .shutter_start(shutter_start),
        .exposure_lines(exposure_lines)
    );

    typedef struct {
        logic  vs, hs, fs, sh;
        line_t expo;
        string tag;
    } exp_t;

    exp_t q[$];
    int   vectors = 0;
    int   errors  = 0;
    bit   mon_on  = 0;
    bit   done    = 0;

    task automatic chk(input string req, input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s (%s) actual=%0d expected=%0d at %0t", req, tag, act, exp, $time);
        end
    endtask

    // Driver side: expected outputs of every clock of one frame
    task automatic push_frame(input int h, input int v, input int s, input int sel,
                              input int w, input string tag);
        int he, ve, se;
        he = (h < 2) ? 2 : h;                                 // R7
        ve = (v < 2) ? 2 : v;                                 // R7
        se = (s < 1) ? 1 : ((s > ve - 1) ? ve - 1 : s);       // R6
        for (int t = 0; t < he * ve; t++) begin
            exp_t e;
            int ln, px;
            ln = t / he;
            px = t % he;
            e.vs   = !(ln < (1 << sel));
            e.hs   = !(px < w);
            e.fs   = (t == 0);
            e.sh   = (px == 0) && (ln == se);
            e.expo = line_t'(ve - se - 1);
            e.tag  = tag;
            q.push_back(e);
        end
    endtask

    task automatic apply(input int h, input int v, input int s, input int sel, input int w);
        line_len        = pix_t'(h);
        frame_len       = line_t'(v);
        shutter_line    = line_t'(s);
        vsync_width_sel = 2'(sel);
        hsync_width     = pix_t'(w);
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Monitor side: pop one expectation per clock and compare at the falling edge
    always @(negedge clk) begin
        if (mon_on && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk("R4", e.tag, int'(vsync_n),       int'(e.vs));
            chk("R2", e.tag, int'(hsync_n),       int'(e.hs));
            chk("R3", e.tag, int'(frame_start),   int'(e.fs));
            chk("R5", e.tag, int'(shutter_start), int'(e.sh));
            chk("R8", e.tag, int'(exposure_lines), int'(e.expo));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired, actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        // Frame A: 8 clocks x 12 lines, shutter 3, 1-line vsync, 2-clock hsync
        apply(8, 12, 3, 0, 2);
        rst = 1'b1;
        step(3);
        // R1: reset state
        chk("R1", "reset", int'(frame_start), 1);
        chk("R1", "reset", int'(vsync_n), 0);
        chk("R1", "reset", int'(hsync_n), 0);
        chk("R1", "reset", int'(exposure_lines), 8);

        push_frame(8, 12, 3, 0, 2,   "R1 first frame");
        push_frame(10, 16, 15, 1, 3, "R9 next frame, shutter at top bound");
        push_frame(12, 10, 0, 3, 4,  "R9 last-clock overwrite, R6 low clamp");
        push_frame(7, 9, 200, 2, 7,  "R6 high clamp, hsync whole line");
        push_frame(1, 1, 5, 2, 1,    "R7 tiny frame");
        push_frame(8, 12, 3, 0, 2,   "R9 back to first set");

        rst    = 1'b0;
        mon_on = 1'b1;
        step(3);
        apply(10, 16, 15, 1, 3);          // governs frame 1
        step(96 - 3);
        step(3);
        apply(6, 20, 50, 2, 1);           // discarded
        step(160 - 1 - 3);
        apply(12, 10, 0, 3, 4);           // lands in the final clock: R9
        step(1);
        step(3);
        apply(7, 9, 200, 2, 7);
        step(120 - 3);
        step(3);
        apply(1, 1, 5, 2, 1);
        step(63 - 3);
        step(3);
        apply(8, 12, 3, 0, 2);
        step(4 - 3);
        wait (q.size() == 0);
        @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule